// File: doc/BRIEF.md
# Four-Phase Handshake Read Link

This block pairs a requesting bus master with a responding storage slave. The two exchange single-word read transfers over a request/acknowledge pair that always returns to zero. Requesting logic pulses a start input together with an address. The master latches the address, raises the read strobe and the request line, and holds them until the slave answers. The slave watches the request, spends a set number of wait cycles, then raises its acknowledge with the data word on the data bundle. The master captures the word on the edge where it first sees the acknowledge. The slave then withdraws its acknowledge. The master withdraws its request last. A one-cycle done pulse tells the requesting logic that the word is ready.

Each side is a separate clocked state machine. The slave holds a read-only storage array whose contents are a fixed arithmetic function of the address. The address width, data width and wait-cycle count are parameters.

Top module: `hs_read_sys`

## Requirements
- R1: While rst is high and on the first cycle after it, bus_req, bus_ack, rd_done and rd_busy are low, and rd_data is zero.
- R2: bus_rw is high in every cycle in which bus_req is high, and marks the transfer as a read.
- R3: bus_ack rises only while bus_req is high. With WAIT_CYC = W, it rises exactly W+2 cycles after bus_req rises.
- R4: bus_ack stays high for exactly one cycle and falls while bus_req is still high.
- R5: bus_req falls only when bus_ack has been low for at least the current and previous cycle.
- R6: The word returned on rd_data for address a equals (a*37 + 11) modulo 2^DATA_W. It stays unchanged until the next transfer completes.
- R7: rd_done is a single-cycle pulse, with bus_req and bus_ack both low in that cycle. Counting the edge that samples rd_start as the first, it is high after rising edge W+5.
- R8: rd_start is ignored while rd_busy is high. A start during a transfer launches no second transfer and produces no second done pulse.
- R9: The address is captured on the edge that accepts rd_start. Changes on rd_addr afterwards do not affect the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Start a read, sampled while idle |
| rd_addr | input | ADDR_W | Read address, captured with rd_start |
| rd_data | output | DATA_W | Last word read |
| rd_done | output | 1 | One-cycle pulse when a read has completed |
| rd_busy | output | 1 | Master is inside a transfer |
| bus_req | output | 1 | Request line from master to slave |
| bus_ack | output | 1 | Acknowledge line from slave to master |
| bus_rw | output | 1 | Read/write strobe, high for read |

## Verification
A master or slave stuck in the wrong state shows up at the ports within a few cycles. A missed handshake phase makes the done pulse arrive at a cycle other than W+5, or never. An ordering fault makes the request fall while the acknowledge is still high. A wrong storage word or a mis-latched address shows up in rd_data on the done cycle of that very transfer. A start leaking through while busy shows as a second done pulse or a changed word within the next W+5 cycles. The sweep reads every address, with and without disturbing the address and start inputs mid-transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        MST_IDLE,
        MST_ADRS,
        MST_GET,
        MST_DONE
    } mst_state_e;

    typedef enum logic [1:0] {
        SLV_START,
        SLV_ADRS,
        SLV_SEND,
        SLV_REL
    } slv_state_e;

    localparam int unsigned WORD_MUL = 37;
    localparam int unsigned WORD_ADD = 11;

    function automatic logic [31:0] mem_word(input int unsigned a);
        return 32'(a * WORD_MUL + WORD_ADD);
    endfunction

endpackage

// File: rtl/hs_master.sv
module hs_master #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              req_o,
    output logic              rw_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] bus_data_i
);
    import hs_pkg::*;

    mst_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MST_IDLE: if (start_i) state_d = MST_ADRS;
            MST_ADRS: if (ack_i)   state_d = MST_GET;
            MST_GET:  if (!ack_i)  state_d = MST_DONE;
            MST_DONE: state_d = MST_IDLE;
            default:  state_d = MST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == MST_IDLE && start_i) addr_q <= addr_i;
            if (state_q == MST_ADRS && ack_i)   data_q <= bus_data_i;
        end
    end

    assign req_o      = (state_q == MST_ADRS) || (state_q == MST_GET);
    assign rw_o       = req_o;
    assign bus_addr_o = addr_q;
    assign done_o     = (state_q == MST_DONE);
    assign busy_o     = (state_q != MST_IDLE);
    assign data_o     = data_q;

endmodule

// File: rtl/hs_slave.sv
module hs_slave #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              rw_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] data_o
);
    import hs_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WAIT_CYC + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC);

    logic [DATA_W-1:0] store [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_store
        assign store[g] = DATA_W'(mem_word(g));
    end

    slv_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLV_START: if (req_i) state_d = SLV_ADRS;
            SLV_ADRS:  if (cnt_q == CNT_LAST) state_d = SLV_SEND;
            SLV_SEND:  state_d = SLV_REL;
            SLV_REL:   if (!req_i) state_d = SLV_START;
            default:   state_d = SLV_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLV_START;
            cnt_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLV_ADRS && state_d == SLV_ADRS) cnt_q <= cnt_q + 1'b1;
            else cnt_q <= '0;
            if (state_d == SLV_SEND && rw_i) data_q <= store[addr_i];
        end
    end

    assign ack_o  = (state_q == SLV_SEND);
    assign data_o = ack_o ? data_q : '0;

endmodule

// File: rtl/hs_read_sys.sv
module hs_read_sys #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic              rd_busy,
    output logic              bus_req,
    output logic              bus_ack,
    output logic              bus_rw
);
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;

    hs_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mst_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (rd_start),
        .addr_i     (rd_addr),
        .data_o     (rd_data),
        .done_o     (rd_done),
        .busy_o     (rd_busy),
        .req_o      (bus_req),
        .rw_o       (bus_rw),
        .bus_addr_o (bus_addr),
        .ack_i      (bus_ack),
        .bus_data_i (bus_data)
    );

    hs_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) slv_i (
        .clk    (clk),
        .rst    (rst),
        .req_i  (bus_req),
        .rw_i   (bus_rw),
        .addr_i (bus_addr),
        .ack_o  (bus_ack),
        .data_o (bus_data)
    );

endmodule

// File: rtl/hs_read_chk.sv
module hs_read_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              ack,
    input logic              rw,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
);
    logic [7:0] req_age;

    always_ff @(posedge clk) begin
        if (rst || !req) req_age <= '0;
        else if (req_age != 8'hFF) req_age <= req_age + 1'b1;
    end

    // R2
    rw_with_req_chk: assert property (@(posedge clk) disable iff (rst) req |-> rw);

    // R3
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst) ack |-> req);

    // R3
    ack_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> req_age == 8'(WAIT_CYC + 2));

    // R4
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);

    // R5
    req_falls_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> (!ack && !$past(ack)));

    // R7
    done_idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!req && !ack));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R6
    done_word_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> data == DATA_W'(hs_pkg::mem_word(int'(addr))));

endmodule

bind hs_read_sys hs_read_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) chk_i (
    .clk  (clk),
    .rst  (rst),
    .req  (bus_req),
    .ack  (bus_ack),
    .rw   (bus_rw),
    .done (rd_done),
    .addr (bus_addr),
    .data (rd_data)
);

// File: tb/hs_read_sys_tb_top.sv
`timescale 1ns/1ps
module hs_read_sys_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int W  = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_start;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          rd_done, rd_busy, bus_req, bus_ack, bus_rw;

    int checks = 0;
    int fails  = 0;
    bit wd_hit = 0;

    always #5 clk = ~clk;

    hs_read_sys #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(W)) dut_i (
        .clk(clk), .rst(rst), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_done(rd_done), .rd_busy(rd_busy),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_rw(bus_rw)
    );

    function automatic logic [DW-1:0] expect_word(input int a);
        return DW'(a * 37 + 11);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0 plain, 1 change address mid-transfer, 2 also pulse start mid-transfer
    task automatic do_read(input int a, input int mode);
        int n = 0;
        int dones = 0;
        logic [DW-1:0] got;
        @(negedge clk);
        rd_start = 1'b1;
        rd_addr  = AW'(a);
        while (!rd_done && n < 60) begin
            @(posedge clk); #1;
            n++;
            if (n == 1) begin
                rd_start = 1'b0;
                if (mode >= 1) rd_addr = ~AW'(a);
                if (mode == 2) rd_start = 1'b1;
            end
            if (n == 4) rd_start = 1'b0;
            if (n == 2) check(rd_busy && bus_req && bus_rw, "R2", int'(bus_rw), 1);
        end
        got = rd_data;
        check(n == W + 5, "R7 latency", n, W + 5);
        check(!bus_req && !bus_ack, "R7 lines low", int'({bus_req, bus_ack}), 0);
        if (mode == 0) check(got == expect_word(a), "R6", int'(got), int'(expect_word(a)));
        else check(got == expect_word(a), "R9", int'(got), int'(expect_word(a)));
        @(posedge clk); #1;
        check(!rd_done, "R7 pulse width", int'(rd_done), 0);
        if (mode == 2) begin
            for (int k = 0; k < W + 8; k++) begin
                if (rd_done || rd_busy) dones++;
                @(posedge clk); #1;
            end
            check(dones == 0, "R8 no second transfer", dones, 0);
            check(rd_data == expect_word(a), "R8 word held", int'(rd_data), int'(expect_word(a)));
        end
    endtask

    task automatic ack_profile();
        int n = 0;
        int req_at = -1;
        int ack_at = -1;
        int ack_len = 0;
        int req_fall = -1;
        int ack_fall = -1;
        @(negedge clk);
        rd_start = 1'b1;
        rd_addr  = 4'd5;
        for (int k = 0; k < W + 10; k++) begin
            @(posedge clk); #1;
            n++;
            rd_start = 1'b0;
            if (bus_req && req_at < 0) req_at = n;
            if (bus_ack && ack_at < 0) ack_at = n;
            if (bus_ack) ack_len++;
            if (bus_ack) check(bus_req, "R3 ack with req", int'(bus_req), 1);
            if (ack_at > 0 && !bus_ack && ack_fall < 0) ack_fall = n;
            if (req_at > 0 && !bus_req && req_fall < 0) req_fall = n;
        end
        check(ack_at - req_at == W + 2, "R3 wait cycles", ack_at - req_at, W + 2);
        check(ack_len == 1, "R4 ack width", ack_len, 1);
        check(req_fall > ack_fall, "R5 req falls last", req_fall, ack_fall + 1);
        check(rd_data == expect_word(5), "R6 word 5", int'(rd_data), int'(expect_word(5)));
    endtask

    initial begin
        #2_000_000;
        wd_hit = 1;
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rd_start = 1'b0;
        rd_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        check(!bus_req && !bus_ack && !rd_done && !rd_busy && rd_data == 0, "R1 in reset",
              int'({bus_req, bus_ack, rd_done, rd_busy}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(!bus_req && !bus_ack && !rd_done && !rd_busy && rd_data == 0, "R1 after reset",
              int'(rd_data), 0);
        for (int a = 0; a < (1 << AW); a++) do_read(a, 0);
        for (int a = 0; a < (1 << AW); a += 3) do_read(a, 1);
        for (int a = 1; a < (1 << AW); a += 4) do_read(a, 2);
        ack_profile();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule